// File: doc/BRIEF.md
# Port Overload Fault Timer

This block decides when an overload on a powered port has gone on long enough to turn the port off. It works on a fine timing tick and runs three timers. The first is an asymmetric integrator: it counts up on every tick while the current sits above the cut threshold. When the current is below the threshold it bleeds back down at one sixteenth of that rate, and it never drops below zero. The second is a run timer for high-power (Class 4) loads. It trips when the current limiter has stayed engaged for too many consecutive ticks. The third is an inrush window, opened by a power-up strobe. The window keeps the fixed inrush current limit selected until the pass switch reports fully on. It flags an error if that report does not arrive in time.

A port sequencer uses the block. It drives `port_on` while the port is powered, pulses `pwr_start` when power-up begins, reads the two latched fault flags, and pulses `fault_clr` once it has dealt with a fault. All timing limits are counted in ticks and set by parameters. With a 1 ms tick the defaults give a 60 ms overload budget, a 15 ms limit-active budget, a 5 ms gate ramp and a 75 ms inrush window.

Top module: `ocp_fault_integrator`

## Requirements
- R1: With `port_on` high, each tick with `over_cut` high adds one to the overload count. The count saturates at OC_TICKS. `oc_fault` rises on the clock after the tick that leaves the count at OC_TICKS. From zero, that takes exactly OC_TICKS ticks above the threshold.
- R2: Each tick with `over_cut` low advances a 4-bit prescaler. The count drops by one only on the tick that wraps the prescaler from 15 to 0. Every tick above the threshold restarts the prescaler at 0. The count never goes below zero.
- R3: A tick with both `hi_power` and `lim_active` high extends a run. A tick without both ends the run. `oc_fault` rises on the clock after the run reaches LIM_TICKS+1 ticks. With `hi_power` low, `lim_active` has no effect.
- R4: `lim_sel` encodes 0 = fixed inrush limit and 1 = class limit. It is 0 after reset and after `pwr_start`. It changes to 1 on the clock after an edge at which the window is open, `sw_full_on` is high, and the ramp has ended.
- R5: `sw_full_on` is ignored until RAMP_TICKS ticks have passed since `pwr_start`. During that time `lim_sel` stays 0.
- R6: If the window sees INRUSH_TICKS ticks without the full-on report being accepted, `inrush_fault` rises, the window closes and `lim_sel` stays 0. A full-on report that is accepted on the same edge as the last tick wins over the fault.
- R7: Both fault flags stay set until `fault_clr` is high at an edge. If a new fault arrives on the same edge as the clear, the flag stays set.
- R8: While `port_on` is low, all three timers and the prescaler go back to zero, the window closes, and `lim_sel` returns to 0. The fault flags keep their values.
- R9: Clocks without `tick` change no timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timing tick enable, one clock wide |
| port_on | input | 1 | Port is powered; low resets the timers |
| pwr_start | input | 1 | Power-up start strobe; opens the inrush window |
| over_cut | input | 1 | Current is above the cut threshold |
| lim_active | input | 1 | Current limiter is engaged |
| hi_power | input | 1 | Port was granted the high-power class |
| sw_full_on | input | 1 | Pass switch is fully enhanced |
| fault_clr | input | 1 | Clears both fault flags |
| oc_fault | output | 1 | Latched overload or limit-timeout fault |
| inrush_fault | output | 1 | Latched inrush-window timeout fault |
| lim_sel | output | 1 | Current limit select: 0 inrush, 1 class |

## Verification
Every result is registered. A tick or level sampled at one rising edge shows up on the outputs right after that edge, with no further delay. The fault that comes from the Nth qualifying tick is therefore visible one clock after that tick is driven. The bench drives inputs and samples outputs on falling edges. Its reference model advances on rising edges, so each falling-edge comparison sees exactly one new edge. The targeted checks stop one tick short of each threshold and check that the output is still low. They then apply the final tick and check that the output is high.

// File: rtl/ocp_pkg.sv
// Package: shared encodings for the port overload fault timer.
// Assumes: nothing beyond the standard types.
package ocp_pkg;
    // Current-limit selection driven to the analog limiter.
    typedef enum logic {
        LIM_INRUSH = 1'b0,
        LIM_CLASS  = 1'b1
    } lim_sel_e;
endpackage

// File: rtl/ocp_integ.sv
// Asymmetric overload integrator: counts up one per tick above threshold,
// down one per 2**DECAY_LOG2 ticks below it, floored at zero, saturating at
// LIMIT. Assumes clr_run is held while the port is unpowered.
module ocp_integ #(
    parameter int unsigned LIMIT      = 60,
    parameter int unsigned DECAY_LOG2 = 4,
    localparam int unsigned CW        = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_run,
    input  logic          tick,
    input  logic          above,
    output logic [CW-1:0] count,
    output logic          hit
);
    logic [CW-1:0]         count_q;
    logic [DECAY_LOG2-1:0] pre_q;

    // Integrator and decay prescaler update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_run) begin
            count_q <= '0;
            pre_q   <= '0;
        end else if (tick) begin
            if (above) begin
                pre_q <= '0;
                if (count_q != CW'(LIMIT)) count_q <= count_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
                if ((&pre_q) && (count_q != '0)) count_q <= count_q - 1'b1;
            end
        end
    end

    // Fault request: this tick leaves the count at the limit.
    assign hit   = tick && above && !clr_run && (count_q >= CW'(LIMIT - 1));
    assign count = count_q;
endmodule

// File: rtl/ocp_lim_timer.sv
// Consecutive limit-active timer for high-power loads. Requests a fault when
// the run of engaged ticks reaches LIMIT+1. Assumes one-clock tick pulses.
module ocp_lim_timer #(
    parameter int unsigned LIMIT = 15,
    localparam int unsigned RW   = $clog2(LIMIT + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_run,
    input  logic tick,
    input  logic engaged,
    output logic hit
);
    logic [RW-1:0] run_q;

    // Run length counter, cleared by any tick without engagement.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_run) begin
            run_q <= '0;
        end else if (tick) begin
            if (!engaged)                       run_q <= '0;
            else if (run_q != RW'(LIMIT + 1))   run_q <= run_q + 1'b1;
        end
    end

    // Fault request: this tick makes the run exceed LIMIT.
    assign hit = tick && engaged && !clr_run && (run_q >= RW'(LIMIT));
endmodule

// File: rtl/ocp_inrush_win.sv
// Inrush window: keeps the inrush limit selected from power-up start until the
// switch reports fully on after the gate ramp; times out after WINDOW ticks.
// Assumes start is a single-clock strobe issued while the port is powered.
module ocp_inrush_win
    import ocp_pkg::*;
#(
    parameter int unsigned WINDOW = 75,
    parameter int unsigned RAMP   = 5,
    localparam int unsigned IW    = $clog2(WINDOW + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr_run,
    input  logic     tick,
    input  logic     start,
    input  logic     full_on,
    output lim_sel_e sel,
    output logic     timeout
);
    logic          active_q;
    logic [IW-1:0] elapsed_q;
    lim_sel_e      sel_q;
    logic          accept;
    logic          last_tick;

    assign accept    = active_q && full_on && (elapsed_q >= IW'(RAMP));
    assign last_tick = active_q && tick && (elapsed_q == IW'(WINDOW - 1));

    // Window state, elapsed tick count and limit selection.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_run) begin
            active_q  <= 1'b0;
            elapsed_q <= '0;
            sel_q     <= LIM_INRUSH;
        end else if (start) begin
            active_q  <= 1'b1;
            elapsed_q <= '0;
            sel_q     <= LIM_INRUSH;
        end else if (accept) begin
            active_q  <= 1'b0;
            sel_q     <= LIM_CLASS;
        end else if (active_q && tick) begin
            elapsed_q <= elapsed_q + 1'b1;
            if (last_tick) active_q <= 1'b0;
        end
    end

    // Timeout request: window expired without an accepted full-on report.
    assign timeout = !clr_run && !start && !accept && last_tick;
    assign sel     = sel_q;
endmodule

// File: rtl/ocp_fault_integrator.sv
// Top: overload fault timer for one powered port. Combines the integrator,
// the high-power limit timer and the inrush window, and latches their fault
// requests until the sequencer clears them. Assumes tick is one clock wide.
module ocp_fault_integrator
    import ocp_pkg::*;
#(
    parameter int unsigned OC_TICKS     = 60,
    parameter int unsigned LIM_TICKS    = 15,
    parameter int unsigned INRUSH_TICKS = 75,
    parameter int unsigned RAMP_TICKS   = 5,
    parameter int unsigned DECAY_LOG2   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic port_on,
    input  logic pwr_start,
    input  logic over_cut,
    input  logic lim_active,
    input  logic hi_power,
    input  logic sw_full_on,
    input  logic fault_clr,
    output logic oc_fault,
    output logic inrush_fault,
    output logic lim_sel
);
    localparam int unsigned CNT_W = $clog2(OC_TICKS + 1);

    logic             clr_run;
    logic [CNT_W-1:0] integ_count;
    logic             integ_hit;
    logic             lim_hit;
    logic             win_timeout;
    lim_sel_e         win_sel;
    logic             oc_q;
    logic             inrush_q;

    assign clr_run = !port_on;

    ocp_integ #(
        .LIMIT      (OC_TICKS),
        .DECAY_LOG2 (DECAY_LOG2)
    ) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_run (clr_run),
        .tick    (tick),
        .above   (over_cut),
        .count   (integ_count),
        .hit     (integ_hit)
    );

    ocp_lim_timer #(
        .LIMIT (LIM_TICKS)
    ) u_lim (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_run (clr_run),
        .tick    (tick),
        .engaged (hi_power && lim_active),
        .hit     (lim_hit)
    );

    ocp_inrush_win #(
        .WINDOW (INRUSH_TICKS),
        .RAMP   (RAMP_TICKS)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_run (clr_run),
        .tick    (tick),
        .start   (pwr_start),
        .full_on (sw_full_on),
        .sel     (win_sel),
        .timeout (win_timeout)
    );

    // Fault latches: a new request wins over a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_q     <= 1'b0;
            inrush_q <= 1'b0;
        end else begin
            oc_q     <= (oc_q && !fault_clr) || integ_hit || lim_hit;
            inrush_q <= (inrush_q && !fault_clr) || win_timeout;
        end
    end

    assign oc_fault     = oc_q;
    assign inrush_fault = inrush_q;
    assign lim_sel      = win_sel;
endmodule

// File: rtl/ocp_fault_checker.sv
// Checker: temporal properties of the overload fault timer, bound to the top.
// Assumes the integrator count is exposed as integ_count in the top scope.
module ocp_fault_checker #(
    parameter int unsigned OC_TICKS = 60,
    localparam int unsigned CW      = $clog2(OC_TICKS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          port_on,
    input logic          over_cut,
    input logic          lim_active,
    input logic          hi_power,
    input logic          sw_full_on,
    input logic          fault_clr,
    input logic          oc_fault,
    input logic          inrush_fault,
    input logic          lim_sel,
    input logic [CW-1:0] integ_count
);
    // R1 / R3: an overload fault only follows a qualifying tick.
    a_r1_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_fault) |-> $past(tick && port_on && (over_cut || (hi_power && lim_active))));

    // R2: a tick below threshold never raises the count.
    a_r2_no_rise_below: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && port_on && !over_cut) |=> (integ_count <= $past(integ_count)));

    // R1: the count never passes its saturation value.
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        integ_count <= CW'(OC_TICKS));

    // R4: the class limit is only selected after a full-on report.
    a_r4_class_after_on: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lim_sel) |-> $past(sw_full_on && port_on));

    // R6: an inrush timeout leaves the inrush limit selected.
    a_r6_timeout_keeps_inrush: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inrush_fault) |-> !lim_sel);

    // R7: fault flags hold without a clear.
    a_r7_oc_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_fault && !fault_clr) |=> oc_fault);
    a_r7_inrush_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (inrush_fault && !fault_clr) |=> inrush_fault);

    // R8: an unpowered port resets the integrator and the limit selection.
    a_r8_port_off: assert property (@(posedge clk) disable iff (!rst_n)
        !port_on |=> (integ_count == '0 && !lim_sel));

    // R9: without a tick the integrator holds.
    a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && port_on) |=> $stable(integ_count));
endmodule

bind ocp_fault_integrator ocp_fault_checker #(
    .OC_TICKS (OC_TICKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .port_on      (port_on),
    .over_cut     (over_cut),
    .lim_active   (lim_active),
    .hi_power     (hi_power),
    .sw_full_on   (sw_full_on),
    .fault_clr    (fault_clr),
    .oc_fault     (oc_fault),
    .inrush_fault (inrush_fault),
    .lim_sel      (lim_sel),
    .integ_count  (integ_count)
);

// File: tb/ocp_fault_integrator_tb.sv
// Bench: behavioural reference model compared on every clock, plus targeted
// threshold checks. Inputs change and outputs are sampled on falling edges.
module ocp_fault_integrator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int OC  = 60;
    localparam int LIM = 15;
    localparam int INR = 75;
    localparam int RMP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, port_on = 1'b0, pwr_start = 1'b0, over_cut = 1'b0;
    logic lim_active = 1'b0, hi_power = 1'b0, sw_full_on = 1'b0, fault_clr = 1'b0;
    logic oc_fault, inrush_fault, lim_sel;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Reference model state.
    int  m_cnt = 0, m_pre = 0, m_run = 0, m_el = 0;
    bit  m_act = 0, m_sel = 0, m_oc = 0, m_in = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocp_fault_integrator u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .port_on(port_on),
        .pwr_start(pwr_start), .over_cut(over_cut), .lim_active(lim_active),
        .hi_power(hi_power), .sw_full_on(sw_full_on), .fault_clr(fault_clr),
        .oc_fault(oc_fault), .inrush_fault(inrush_fault), .lim_sel(lim_sel)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at cycle %0d", req, got, exp, cycles);
        end
    endtask

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        bit set_oc, set_in;
        cycles++;
        set_oc = 0;
        set_in = 0;
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_run = 0; m_el = 0;
            m_act = 0; m_sel = 0; m_oc = 0; m_in = 0;
        end else begin
            if (!port_on) begin
                m_cnt = 0; m_pre = 0; m_run = 0; m_el = 0; m_act = 0; m_sel = 0;
            end else begin
                if (tick) begin
                    if (over_cut) begin
                        m_pre = 0;
                        if (m_cnt < OC) m_cnt++;
                        if (m_cnt == OC) set_oc = 1;
                    end else begin
                        if (m_pre == 15) begin
                            m_pre = 0;
                            if (m_cnt > 0) m_cnt--;
                        end else m_pre++;
                    end
                    if (hi_power && lim_active) begin
                        if (m_run <= LIM) m_run++;
                        if (m_run == LIM + 1) set_oc = 1;
                    end else m_run = 0;
                end
                if (pwr_start) begin
                    m_act = 1; m_el = 0; m_sel = 0;
                end else if (m_act) begin
                    if (sw_full_on && m_el >= RMP) begin
                        m_act = 0; m_sel = 1;
                    end else if (tick) begin
                        m_el++;
                        if (m_el == INR) begin m_act = 0; set_in = 1; end
                    end
                end
            end
            m_oc = (m_oc && !fault_clr) || set_oc;
            m_in = (m_in && !fault_clr) || set_in;
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("model oc_fault", oc_fault, m_oc);
            chk("model inrush_fault", inrush_fault, m_in);
            chk("model lim_sel", lim_sel, m_sel);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycles > 50000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic port_reset();
        port_on = 0; fault_clr = 1; over_cut = 0; lim_active = 0; hi_power = 0;
        sw_full_on = 0; tick = 1;
        run(1);
        port_on = 1; fault_clr = 0;
    endtask

    initial begin
        run(3);
        chk("reset oc_fault", oc_fault, 1'b0);
        chk("reset inrush_fault", inrush_fault, 1'b0);
        chk("reset lim_sel", lim_sel, 1'b0);
        rst_n = 1; port_on = 1; tick = 1;

        // R1: fault after exactly OC ticks above threshold.
        over_cut = 1; run(OC - 1);
        chk("R1 one tick short", oc_fault, 1'b0);
        run(1);
        chk("R1 at limit", oc_fault, 1'b1);

        // R7: clear, then set wins over clear on the same edge, then latch.
        over_cut = 0; fault_clr = 1; run(1);
        chk("R7 cleared", oc_fault, 1'b0);
        over_cut = 1; run(1);
        chk("R7 set wins over clear", oc_fault, 1'b1);
        fault_clr = 0; over_cut = 0; run(5);
        chk("R7 latched", oc_fault, 1'b1);

        // R8: port off keeps flags, resets timers.
        port_on = 0; run(1);
        chk("R8 flag kept", oc_fault, 1'b1);
        chk("R8 lim_sel inrush", lim_sel, 1'b0);
        port_on = 1; fault_clr = 1; run(1);
        fault_clr = 0; over_cut = 1; run(OC - 1);
        chk("R8 count restarted", oc_fault, 1'b0);

        // R2: full decay to zero and floor.
        over_cut = 0; run(16 * (OC - 1) + 50);
        over_cut = 1; run(OC - 1);
        chk("R2 floor short", oc_fault, 1'b0);
        run(1);
        chk("R2 floor at limit", oc_fault, 1'b1);
        port_reset();

        // R2: decay rate 1/16.
        over_cut = 1; run(30);
        over_cut = 0; run(160);
        over_cut = 1; run(39);
        chk("R2 decay short", oc_fault, 1'b0);
        run(1);
        chk("R2 decay at limit", oc_fault, 1'b1);
        port_reset();

        // R2: prescaler restarts on each tick above threshold.
        over_cut = 1; run(50);
        for (int k = 0; k < 10; k++) begin
            over_cut = 0; run(15);
            over_cut = 1; run(1);
            if (k == 8) chk("R2 prescaler short", oc_fault, 1'b0);
        end
        chk("R2 prescaler restart", oc_fault, 1'b1);
        port_reset();

        // R9: no tick, no count.
        tick = 0; over_cut = 1; run(200);
        chk("R9 no tick", oc_fault, 1'b0);
        tick = 1; run(OC);
        chk("R9 ticks resume", oc_fault, 1'b1);
        port_reset();

        // R3: limit-active run timeout for high-power loads.
        hi_power = 1; lim_active = 1; run(LIM);
        chk("R3 run short", oc_fault, 1'b0);
        run(1);
        chk("R3 run exceeded", oc_fault, 1'b1);
        port_reset();
        hi_power = 1; lim_active = 1; run(LIM);
        lim_active = 0; run(1);
        lim_active = 1; run(LIM);
        chk("R3 broken run", oc_fault, 1'b0);
        run(1);
        chk("R3 new run exceeded", oc_fault, 1'b1);
        port_reset();
        lim_active = 1; run(100);
        chk("R3 low power ignored", oc_fault, 1'b0);
        lim_active = 0;

        // R4/R5: ramp then class limit.
        pwr_start = 1; run(1); pwr_start = 0;
        chk("R4 inrush after start", lim_sel, 1'b0);
        sw_full_on = 1; run(RMP);
        chk("R5 ramp ignores full-on", lim_sel, 1'b0);
        run(1);
        chk("R4 class after full-on", lim_sel, 1'b1);

        // R6: inrush timeout.
        sw_full_on = 0; pwr_start = 1; run(1); pwr_start = 0;
        run(INR - 1);
        chk("R6 window short", inrush_fault, 1'b0);
        run(1);
        chk("R6 timeout", inrush_fault, 1'b1);
        chk("R6 inrush kept", lim_sel, 1'b0);
        sw_full_on = 1; run(2);
        chk("R6 closed window", lim_sel, 1'b0);
        sw_full_on = 0; fault_clr = 1; run(1); fault_clr = 0;
        chk("R7 inrush cleared", inrush_fault, 1'b0);

        // R6: full-on on the last tick wins.
        pwr_start = 1; run(1); pwr_start = 0;
        run(INR - 1);
        sw_full_on = 1; run(1);
        chk("R6 tie no fault", inrush_fault, 1'b0);
        chk("R6 tie class", lim_sel, 1'b1);

        // R8: port off returns to inrush limit.
        port_on = 0; run(1);
        chk("R8 off selects inrush", lim_sel, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule